// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary with End-of-Service Re-arm

This block gathers the pending flags of a large set of pins into a compact summary, one bit per group of four neighbouring pins. A pin counts as pending when its interrupt flag or its wake flag is set. The summary is registered once. It is presented to software as two 32-bit read-only words. The low word holds summary bits 0 to 31. The high word holds the remaining bits, and every unused position in it is zero.

A single upstream interrupt line is raised when the summary becomes non-zero while the line is armed. The line then stays raised and disarmed, whatever the summary does afterwards. Software clears the per-pin flags, then writes the end-of-service bit of the control register. That write drops the line and re-arms it. If pins are still pending at that point, the line rises again one cycle later.

The control register keeps its other bits as plain storage. The end-of-service bit clears itself.

Top module: `irq_summary_aggr`

## Requirements
- R1: Summary bit k is the OR of the interrupt and wake flags of pins 4k, 4k+1, 4k+2 and 4k+3, and appears on the summary words one clock after the flags are sampled.
- R2: `sum_lo[j]` is summary bit j for j = 0..31. `sum_hi[j]` is summary bit 32+j for j = 0..13. `sum_hi[31:14]` is always 0.
- R3: While `rst_n` is low at a clock edge, the next cycle shows both summary words at 0, `irq_out` at 0, the line armed and `master_rdata` at 0.
- R4: While the line is armed (`irq_out` low), a non-zero summary raises `irq_out` one clock later. Once high, `irq_out` stays high even if the summary returns to zero, until an end-of-service write.
- R5: An end-of-service write is `wr_en`=1, `wr_addr`=2 and `wr_data[29]`=1. With `irq_out` high, it drops `irq_out` at the next clock. If the summary is still non-zero, `irq_out` rises again on the clock after that.
- R6: An end-of-service write while `irq_out` is low has no effect on the line. If the summary is non-zero in that same cycle, `irq_out` still rises at the next clock.
- R7: A write to `wr_addr`=2 stores `wr_data` into the control register except bit 29. `master_rdata[29]` always reads 0.
- R8: Writes to `wr_addr` 0 (low summary word), 1 (high summary word) and 3 (unused) are ignored. They do not change the summary words or `master_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_int_sts | input | 184 | Per-pin interrupt pending flags |
| pin_wake_sts | input | 184 | Per-pin wake pending flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index: 0 low word, 1 high word, 2 control, 3 unused |
| wr_data | input | 32 | Register write data |
| sum_lo | output | 32 | Summary bits 0..31 |
| sum_hi | output | 32 | Summary bits 32..45, upper bits zero |
| master_rdata | output | 32 | Control register read value, bit 29 always 0 |
| irq_out | output | 1 | Upstream interrupt line |

## Verification
Two of this block's functions can land in the same cycle: the armed line firing on a non-zero summary, and an end-of-service write. The bench provokes this by setting a pin flag, then issuing the end-of-service write in the very cycle the summary first shows non-zero while the line is still low. The firing must win, so `irq_out` is expected high on the following clock. The bench also covers the opposite order: an end-of-service write while the line is high and pins are still pending must produce one low cycle and then a fresh rise.

// File: rtl/irq_aggr_pkg.sv
// Shared parameters and register index type for the interrupt summary block.
// Assumes the register index is two bits wide and decoded exactly.
package irq_aggr_pkg;

    // Register indices seen on wr_addr
    typedef enum logic [1:0] {
        REG_SUM_LO = 2'd0,
        REG_SUM_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_SPARE  = 2'd3
    } aggr_reg_e;

    // Default geometry
    localparam int unsigned DEF_NUM_PINS = 184;
    localparam int unsigned DEF_GROUP    = 4;
    localparam int unsigned DEF_WORD_W   = 32;
    localparam int unsigned DEF_EOI_BIT  = 29;

endpackage

// File: rtl/aggr_group_or.sv
// Folds per-pin interrupt and wake flags into one registered bit per group of
// GROUP consecutive pins. Assumes pins beyond NUM_PINS in the last group are
// absent (treated as 0).
module aggr_group_or #(
    parameter int unsigned NUM_PINS = 184,
    parameter int unsigned GROUP    = 4,
    parameter int unsigned SUM_BITS = (NUM_PINS + GROUP - 1) / GROUP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] int_sts,
    input  logic [NUM_PINS-1:0] wake_sts,
    output logic [SUM_BITS-1:0] sum_q
);
    localparam int unsigned PAD_W = SUM_BITS * GROUP;

    logic [PAD_W-1:0]    pend_pad;
    logic [SUM_BITS-1:0] sum_d;

    // Merge both flag kinds and pad the vector to whole groups
    always_comb begin
        pend_pad                 = '0;
        pend_pad[NUM_PINS-1:0]   = int_sts | wake_sts;
    end

    // One OR reduction per group
    for (genvar k = 0; k < SUM_BITS; k++) begin : g_grp
        assign sum_d[k] = |pend_pad[k*GROUP +: GROUP];
    end

    // Register the summary so software sees a clean, aligned snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end
endmodule

// File: rtl/aggr_word_split.sv
// Places the summary vector into two WORD_W-bit read words, zero-filling any
// position above SUM_BITS. Assumes SUM_BITS fits in two words.
module aggr_word_split #(
    parameter int unsigned SUM_BITS = 46,
    parameter int unsigned WORD_W   = 32
) (
    input  logic [SUM_BITS-1:0] sum_in,
    output logic [WORD_W-1:0]   word_lo,
    output logic [WORD_W-1:0]   word_hi
);
    localparam int unsigned FULL_W = 2 * WORD_W;

    logic [FULL_W-1:0] full;

    // Zero-extend the summary to the two-word span
    always_comb begin
        full                 = '0;
        full[SUM_BITS-1:0]   = sum_in;
    end

    assign word_lo = full[WORD_W-1:0];
    assign word_hi = full[FULL_W-1:WORD_W];
endmodule

// File: rtl/aggr_ctrl_reg.sv
// Control register: stores written data except the self-clearing
// end-of-service bit, which is turned into a single-cycle pulse instead.
// Assumes writes to other indices are not meant for this register.
module aggr_ctrl_reg
    import irq_aggr_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned EOI_BIT = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rdata,
    output logic              eoi_pulse
);
    localparam logic [WORD_W-1:0] KEEP_MASK = ~(WORD_W'(1) << EOI_BIT);

    logic hit;

    // Decode a write aimed at the control register
    assign hit       = wr_en && (aggr_reg_e'(wr_addr) == REG_CTRL);
    assign eoi_pulse = hit && wr_data[EOI_BIT];

    // Hold the storage bits; the end-of-service bit is never stored
    always_ff @(posedge clk) begin
        if (!rst_n)   rdata <= '0;
        else if (hit) rdata <= wr_data & KEEP_MASK;
    end
endmodule

// File: rtl/aggr_irq_gate.sv
// One-shot upstream interrupt: fires when armed and the summary is non-zero,
// then holds until an end-of-service pulse. A low line means armed.
module aggr_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi_pulse,
    output logic irq_q
);
    // Raise when armed and pending; drop only on end-of-service
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (irq_q) irq_q <= !eoi_pulse;
        else            irq_q <= any_pend;
    end
endmodule

// File: rtl/irq_summary_aggr.sv
// Top of the grouped pin interrupt summary. Folds pin flags into a summary,
// exposes it as two read words, and gates one upstream line with an
// end-of-service re-arm. Assumes the summary fits in two words.
module irq_summary_aggr
    import irq_aggr_pkg::*;
#(
    parameter int unsigned NUM_PINS = DEF_NUM_PINS,
    parameter int unsigned GROUP    = DEF_GROUP,
    parameter int unsigned WORD_W   = DEF_WORD_W,
    parameter int unsigned EOI_BIT  = DEF_EOI_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_int_sts,
    input  logic [NUM_PINS-1:0] pin_wake_sts,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   sum_lo,
    output logic [WORD_W-1:0]   sum_hi,
    output logic [WORD_W-1:0]   master_rdata,
    output logic                irq_out
);
    localparam int unsigned SUM_BITS = (NUM_PINS + GROUP - 1) / GROUP;

    logic [SUM_BITS-1:0] sum_q;
    logic                eoi_pulse;

    aggr_group_or #(
        .NUM_PINS (NUM_PINS),
        .GROUP    (GROUP),
        .SUM_BITS (SUM_BITS)
    ) u_group (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_sts  (pin_int_sts),
        .wake_sts (pin_wake_sts),
        .sum_q    (sum_q)
    );

    aggr_word_split #(
        .SUM_BITS (SUM_BITS),
        .WORD_W   (WORD_W)
    ) u_split (
        .sum_in  (sum_q),
        .word_lo (sum_lo),
        .word_hi (sum_hi)
    );

    aggr_ctrl_reg #(
        .WORD_W  (WORD_W),
        .EOI_BIT (EOI_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rdata     (master_rdata),
        .eoi_pulse (eoi_pulse)
    );

    aggr_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_pend  (|sum_q),
        .eoi_pulse (eoi_pulse),
        .irq_q     (irq_out)
    );
endmodule

// File: rtl/irq_summary_aggr_chk.sv
// Port-level property checker for irq_summary_aggr, attached by bind.
module irq_summary_aggr_chk #(
    parameter int unsigned NUM_PINS = 184,
    parameter int unsigned GROUP    = 4,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned EOI_BIT  = 29
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_int_sts,
    input logic [NUM_PINS-1:0] pin_wake_sts,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [WORD_W-1:0]   wr_data,
    input logic [WORD_W-1:0]   sum_lo,
    input logic [WORD_W-1:0]   sum_hi,
    input logic [WORD_W-1:0]   master_rdata,
    input logic                irq_out
);
    localparam int unsigned SUM_BITS = (NUM_PINS + GROUP - 1) / GROUP;
    localparam int unsigned HI_USED  = SUM_BITS - WORD_W;

    logic eoi_wr;
    logic any_sum;
    assign eoi_wr  = wr_en && (wr_addr == 2'd2) && wr_data[EOI_BIT];
    assign any_sum = (sum_lo != '0) || (sum_hi != '0);

    // R3: reset clears everything visible
    p_reset_clear_r3: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && sum_lo == '0 && sum_hi == '0 && master_rdata == '0));

    // R1: no flags in, empty summary out
    p_empty_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_int_sts == '0 && pin_wake_sts == '0) |=> (sum_lo == '0 && sum_hi == '0));

    // R2: unused high-word bits stay zero
    p_hi_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sum_hi[WORD_W-1:HI_USED] == '0);

    // R4 and R6: armed line with pending summary fires next cycle
    p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && any_sum) |=> irq_out);

    // R4: raised line holds without end-of-service
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !eoi_wr) |=> irq_out);

    // R5: end-of-service drops a raised line
    p_eoi_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && eoi_wr) |=> !irq_out);

    // R7: end-of-service bit reads back as 0
    p_eoi_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        master_rdata[EOI_BIT] == 1'b0);

    // R8: writes elsewhere leave the control register alone
    p_other_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 2'd2) |=> $stable(master_rdata));
endmodule

bind irq_summary_aggr irq_summary_aggr_chk #(
    .NUM_PINS (NUM_PINS),
    .GROUP    (GROUP),
    .WORD_W   (WORD_W),
    .EOI_BIT  (EOI_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_int_sts  (pin_int_sts),
    .pin_wake_sts (pin_wake_sts),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .sum_lo       (sum_lo),
    .sum_hi       (sum_hi),
    .master_rdata (master_rdata),
    .irq_out      (irq_out)
);

// File: tb/irq_summary_aggr_tb.sv
module irq_summary_aggr_tb;
    localparam int NP = 184;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin_int_sts;
    logic [NP-1:0] pin_wake_sts;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [31:0]   wr_data;
    logic [31:0]   sum_lo, sum_hi, master_rdata;
    logic          irq_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_summary_aggr u_dut (
        .clk(clk), .rst_n(rst_n),
        .pin_int_sts(pin_int_sts), .pin_wake_sts(pin_wake_sts),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sum_lo(sum_lo), .sum_hi(sum_hi), .master_rdata(master_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    endtask

    task automatic clear_pins();
        pin_int_sts = '0; pin_wake_sts = '0;
    endtask

    // Expected summary words for a single pending pin
    function automatic logic [63:0] exp_words(input int pin);
        logic [63:0] s;
        s = 64'd1 << (pin / 4);
        return s;
    endfunction

    localparam logic [31:0] EOI = 32'h2000_0000;

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        clear_pins();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: reset state
        chk("R3 irq", {63'd0, irq_out}, 64'd0);
        chk("R3 words", {sum_hi, sum_lo}, 64'd0);
        chk("R3 ctrl", {32'd0, master_rdata}, 64'd0);

        // R1/R2: sweep every pin through both flag kinds
        for (int n = 0; n < NP; n++) begin
            for (int kind = 0; kind < 2; kind++) begin
                clear_pins();
                if (kind == 0) pin_int_sts[n] = 1'b1;
                else           pin_wake_sts[n] = 1'b1;
                @(negedge clk);
                chk(kind == 0 ? "R1 R2 int pin" : "R1 R2 wake pin",
                    {sum_hi, sum_lo}, exp_words(n));
            end
        end
        // R2: every pin pending fills all used bits, pad stays zero
        pin_int_sts = '1;
        @(negedge clk);
        chk("R2 all lo", {32'd0, sum_lo}, 64'hFFFF_FFFF);
        chk("R2 all hi", {32'd0, sum_hi}, 64'h3FFF);
        // R1: mixed kinds in one group still one bit
        clear_pins();
        pin_int_sts[8] = 1'b1; pin_wake_sts[11] = 1'b1; pin_wake_sts[183] = 1'b1;
        @(negedge clk);
        chk("R1 mixed", {sum_hi, sum_lo}, (64'd1 << 2) | (64'd1 << 45));
        clear_pins();
        @(negedge clk);
        chk("R1 cleared", {sum_hi, sum_lo}, 64'd0);
        // line fired during sweep; service it
        wr(2'd2, EOI);
        @(negedge clk);
        chk("R5 drop after sweep", {63'd0, irq_out}, 64'd0);

        // R4: latency and hold
        pin_int_sts[5] = 1'b1;
        @(negedge clk);
        chk("R4 not yet", {63'd0, irq_out}, 64'd0);
        @(negedge clk);
        chk("R4 rise", {63'd0, irq_out}, 64'd1);
        clear_pins();
        repeat (3) @(negedge clk);
        chk("R4 hold", {63'd0, irq_out}, 64'd1);
        // R5: EOI drops, no re-fire when empty
        wr(2'd2, EOI);
        chk("R5 drop", {63'd0, irq_out}, 64'd0);
        @(negedge clk);
        chk("R5 stays low", {63'd0, irq_out}, 64'd0);
        // R5: EOI with still-pending pins gives one low cycle then a rise
        pin_wake_sts[100] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 rise wake", {63'd0, irq_out}, 64'd1);
        wr(2'd2, EOI);
        chk("R5 low cycle", {63'd0, irq_out}, 64'd0);
        @(negedge clk);
        chk("R5 re-assert", {63'd0, irq_out}, 64'd1);
        clear_pins();
        @(negedge clk);
        wr(2'd2, EOI);
        @(negedge clk);
        chk("R5 idle", {63'd0, irq_out}, 64'd0);

        // R6: EOI while armed and empty has no effect
        wr(2'd2, EOI);
        chk("R6 armed eoi", {63'd0, irq_out}, 64'd0);
        // R6: EOI in the cycle the summary first shows pending; firing wins
        pin_int_sts[60] = 1'b1;
        @(negedge clk);
        chk("R6 summary up", {sum_hi, sum_lo}, exp_words(60));
        wr(2'd2, EOI);
        chk("R6 fire wins", {63'd0, irq_out}, 64'd1);
        @(negedge clk);
        chk("R6 still high", {63'd0, irq_out}, 64'd1);

        // R7: storage bits kept, end-of-service bit reads 0
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R7 all ones", {32'd0, master_rdata}, 64'hDFFF_FFFF);
        chk("R5 via all-ones write", {63'd0, irq_out}, 64'd0);
        wr(2'd2, 32'hA5A5_A5A5);
        chk("R7 pattern", {32'd0, master_rdata}, 64'h85A5_A5A5);

        // R8: writes to summary words and spare index are ignored
        wr(2'd0, 32'h0);
        chk("R8 lo kept", {sum_hi, sum_lo}, exp_words(60));
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R8 hi kept", {sum_hi, sum_lo}, exp_words(60));
        wr(2'd3, EOI | 32'h1);
        chk("R8 ctrl kept", {32'd0, master_rdata}, 64'h85A5_A5A5);
        chk("R8 irq kept", {63'd0, irq_out}, 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule